// File: doc/BRIEF.md
# Oxide Breakdown Test Sequencer

This block steps an SRAM array through an in-field gate-oxide health check, one word line at a time, while leaving the cell array itself untouched. When a scan is started it visits every row in turn. For each row it runs a short fixed sequence on the array's periphery. First comes a pull-up phase, in which both bit-lines of each selected column are pulled to ground and then left floating so the cell's load transistors charge them. Then comes a read-like pull-down phase, in which the bit-lines are precharged and then discharged through the cell. Sense latches outside this block compare the resulting currents against a trigger point and return one pass/fail bit per column for each phase.

The pull-up phase destroys the stored word. The sequencer can therefore copy the row into a holding register before testing it and write it back afterwards. This save and restore can be turned off when the array holds nothing worth keeping, for example at power-up. A reduced mode skips the pull-up phase entirely. It runs only the read-like phase, which leaves the data intact and needs no save or restore. Failing columns are gathered per row and reported with the row address. Normal accesses are held off while a scan runs, and a done flag marks the end of a full pass over the rows.

Top module: `obd_test_seq`

## Requirements
- R1: After reset the block is idle: busy_o, stall_o, done_o, fault_o, every array control output and every strobe are low, and row_o is 0.
- R2: With keep_i high and quick_i low at start, each row begins with one save cycle in which rd_o and wl_en_o are high; rdata_i is captured into the holding register at the end of that cycle.
- R3: The first pull-up cycle drives pch_dis_o, we_o, bl_gnd_o and wl_en_o all high.
- R4: The second pull-up cycle keeps pch_dis_o and wl_en_o high, drops we_o and bl_gnd_o, and raises strobe_up_o; fail_up_i is sampled at the end of this cycle.
- R5: The read-like phase takes two cycles. In the first, precharge is applied (pch_dis_o low) and wl_en_o is low. In the second, pch_dis_o and wl_en_o are high and strobe_dn_o is high; fail_dn_i is sampled at the end of this cycle.
- R6: In save mode, the cycle after the sense cycle is a restore cycle: we_o and wl_en_o are high, bl_gnd_o is low and wdata_o equals the word captured in the save cycle.
- R7: With keep_i low (and quick_i low), no save or restore cycle occurs, rd_o stays low, and each row takes exactly four cycles, starting with the grounding cycle.
- R8: With quick_i high at start, each row takes exactly two cycles (precharge, then sense). we_o and bl_gnd_o stay low for the whole scan.
- R9: At the end of a row's sense cycle, if any bit of (fail_up_i captured this row | fail_dn_i) is set, fault_o rises and stays high, fault_row_o takes that row and fault_cols_o takes that OR. A row with no failing column leaves the record unchanged. A new scan clears the record.
- R10: row_o starts at 0 and increments after each row's last cycle. After row ROWS-1 the block returns to idle with row_o 0 and done_o high. done_o stays high until the next start.
- R11: busy_o is high in every cycle of a scan, and stall_o equals req_i while busy_o is high and is low otherwise.
- R12: test_en_i, quick_i and keep_i are sampled only when idle. Changing them during a scan does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| test_en_i | input | 1 | Starts a scan when idle |
| quick_i | input | 1 | Reduced mode: read-like phase only |
| keep_i | input | 1 | Save each row before test and restore it after |
| req_i | input | 1 | Normal access request from the host side |
| rdata_i | input | WIDTH | Array read data during the save cycle |
| fail_up_i | input | WIDTH | Per-column fail bits from the pull-up sense |
| fail_dn_i | input | WIDTH | Per-column fail bits from the pull-down sense |
| busy_o | output | 1 | Scan in progress |
| stall_o | output | 1 | Hold-off for a normal access |
| pch_dis_o | output | 1 | Suppress bit-line precharge |
| we_o | output | 1 | Array write enable |
| bl_gnd_o | output | 1 | Pull both bit-lines of each column to ground |
| wl_en_o | output | 1 | Assert the word line of row_o |
| col_sel_o | output | 1 | Route the word's columns to the test path |
| rd_o | output | 1 | Array read for the save step |
| strobe_up_o | output | 1 | Latch pull-up sense results |
| strobe_dn_o | output | 1 | Latch pull-down sense results |
| row_o | output | ROW_W | Row under test |
| wdata_o | output | WIDTH | Saved word for the restore write |
| fault_o | output | 1 | At least one failing column seen this scan |
| fault_row_o | output | ROW_W | Last row that showed a failure |
| fault_cols_o | output | WIDTH | Failing columns of that row |
| done_o | output | 1 | Full pass over all rows finished |

## Verification
The bench builds the block with ROWS = 4 and WIDTH = 8. At that size each of the three modes can be run over the whole array, including the wrap from the last row back to idle and the done flag. Short words keep the per-row fail patterns readable, so the fault record can be followed from row to row. That covers a row that overwrites an earlier record and a clean row that must leave the record alone. Mode inputs are toggled during a quick scan to show that the sampled mode holds until the scan ends.

// File: rtl/obd_pkg.sv
package obd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE,
    ST_GND,
    ST_FLT,
    ST_PRE,
    ST_SNS,
    ST_RSTR
  } obd_st_e;

  typedef struct packed {
    logic pch_dis;
    logic we;
    logic bl_gnd;
    logic wl_en;
    logic col_sel;
    logic rd;
    logic stb_up;
    logic stb_dn;
  } obd_ctl_t;

endpackage

// File: rtl/obd_seq_fsm.sv
module obd_seq_fsm
  import obd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     test_en_i,
  input  logic     quick_i,
  input  logic     keep_i,
  input  logic     last_row_i,
  output obd_ctl_t ctl_o,
  output logic     start_o,
  output logic     row_end_o,
  output logic     cap_o,
  output logic     busy_o,
  output logic     done_o
);

  obd_st_e st_q, st_d, first_st;
  logic    quick_q, keep_q, done_q;
  logic    restore_en;

  assign restore_en = keep_q && !quick_q;
  assign first_st   = quick_q ? ST_PRE : (keep_q ? ST_SAVE : ST_GND);
  assign start_o    = (st_q == ST_IDLE) && test_en_i;
  assign row_end_o  = (st_q == ST_RSTR) || ((st_q == ST_SNS) && !restore_en);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (test_en_i) st_d = quick_i ? ST_PRE : (keep_i ? ST_SAVE : ST_GND);
      ST_SAVE: st_d = ST_GND;
      ST_GND:  st_d = ST_FLT;
      ST_FLT:  st_d = ST_PRE;
      ST_PRE:  st_d = ST_SNS;
      ST_SNS:  st_d = restore_en ? ST_RSTR : (last_row_i ? ST_IDLE : first_st);
      ST_RSTR: st_d = last_row_i ? ST_IDLE : first_st;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      quick_q <= 1'b0;
      keep_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_o) begin
        quick_q <= quick_i;
        keep_q  <= keep_i;
        done_q  <= 1'b0;
      end else if (row_end_o && last_row_i) begin
        done_q <= 1'b1;
      end
    end
  end

  // Moore decode of array controls
  always_comb begin
    ctl_o = '0;
    unique case (st_q)
      ST_SAVE: begin ctl_o.wl_en = 1'b1; ctl_o.rd = 1'b1; ctl_o.col_sel = 1'b1; end
      ST_GND: begin
        ctl_o.pch_dis = 1'b1; ctl_o.we = 1'b1; ctl_o.bl_gnd = 1'b1;
        ctl_o.wl_en = 1'b1; ctl_o.col_sel = 1'b1;
      end
      ST_FLT: begin
        ctl_o.pch_dis = 1'b1; ctl_o.wl_en = 1'b1; ctl_o.col_sel = 1'b1; ctl_o.stb_up = 1'b1;
      end
      ST_PRE: ctl_o.col_sel = 1'b1;
      ST_SNS: begin
        ctl_o.pch_dis = 1'b1; ctl_o.wl_en = 1'b1; ctl_o.col_sel = 1'b1; ctl_o.stb_dn = 1'b1;
      end
      ST_RSTR: begin ctl_o.we = 1'b1; ctl_o.wl_en = 1'b1; ctl_o.col_sel = 1'b1; end
      default: ctl_o = '0;
    endcase
  end

  assign cap_o  = (st_q == ST_SAVE);
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;

  AST_SAVE_THEN_GND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.rd |=> ctl_o.bl_gnd); // R2
  AST_GND_THEN_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.bl_gnd |=> (ctl_o.stb_up && !ctl_o.we)); // R4
  AST_PRE_THEN_SENSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PRE) |=> ctl_o.stb_dn); // R5
  AST_RESTORE_AFTER_SENSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RSTR) |-> $past(ctl_o.stb_dn)); // R6
  AST_QUICK_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && quick_q) |-> !ctl_o.we); // R8
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(quick_q)); // R12

endmodule

// File: rtl/obd_row_ctr.sv
module obd_row_ctr #(
  parameter int unsigned ROWS  = 64,
  parameter int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [ROW_W-1:0] row_o,
  output logic             last_o
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q;

  assign last_o = (row_q == LAST_ROW);
  assign row_o  = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       row_q <= '0;
    else if (clr_i)    row_q <= '0;
    else if (inc_i)    row_q <= last_o ? '0 : row_q + ROW_W'(1);
  end

  AST_ROW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_q <= LAST_ROW); // R10
  AST_ROW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !last_o) |=> (row_q == $past(row_q) + ROW_W'(1))); // R10

endmodule

// File: rtl/obd_hold_reg.sv
module obd_hold_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= '0;
    else if (cap_i) q_q <= d_i;
  end

  assign q_o = q_q;

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(q_q)); // R6

endmodule

// File: rtl/obd_fail_rec.sv
module obd_fail_rec #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned ROW_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             up_stb_i,
  input  logic             dn_stb_i,
  input  logic [WIDTH-1:0] up_i,
  input  logic [WIDTH-1:0] dn_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             fault_o,
  output logic [ROW_W-1:0] fault_row_o,
  output logic [WIDTH-1:0] fault_cols_o
);

  logic [WIDTH-1:0] acc_q, row_fail;
  logic             fault_q;
  logic [ROW_W-1:0] frow_q;
  logic [WIDTH-1:0] fcols_q;

  assign row_fail = acc_q | dn_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      fault_q <= 1'b0;
      frow_q  <= '0;
      fcols_q <= '0;
    end else if (clr_i) begin
      acc_q   <= '0;
      fault_q <= 1'b0;
      frow_q  <= '0;
      fcols_q <= '0;
    end else begin
      if (up_stb_i) acc_q <= acc_q | up_i;
      if (dn_stb_i) begin
        acc_q <= '0;
        if (|row_fail) begin
          fault_q <= 1'b1;
          frow_q  <= row_i;
          fcols_q <= row_fail;
        end
      end
    end
  end

  assign fault_o      = fault_q;
  assign fault_row_o  = frow_q;
  assign fault_cols_o = fcols_q;

  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !clr_i) |=> fault_q); // R9
  AST_RECORD_ONLY_AT_SENSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dn_stb_i && !clr_i) |=> ($stable(frow_q) && $stable(fcols_q))); // R9

endmodule

// File: rtl/obd_test_seq.sv
module obd_test_seq
  import obd_pkg::*;
#(
  parameter int unsigned ROWS  = 64,
  parameter int unsigned WIDTH = 32,
  parameter int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             test_en_i,
  input  logic             quick_i,
  input  logic             keep_i,
  input  logic             req_i,
  input  logic [WIDTH-1:0] rdata_i,
  input  logic [WIDTH-1:0] fail_up_i,
  input  logic [WIDTH-1:0] fail_dn_i,
  output logic             busy_o,
  output logic             stall_o,
  output logic             pch_dis_o,
  output logic             we_o,
  output logic             bl_gnd_o,
  output logic             wl_en_o,
  output logic             col_sel_o,
  output logic             rd_o,
  output logic             strobe_up_o,
  output logic             strobe_dn_o,
  output logic [ROW_W-1:0] row_o,
  output logic [WIDTH-1:0] wdata_o,
  output logic             fault_o,
  output logic [ROW_W-1:0] fault_row_o,
  output logic [WIDTH-1:0] fault_cols_o,
  output logic             done_o
);

  obd_ctl_t ctl;
  logic     start, row_end, cap, last_row, busy;

  obd_seq_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .test_en_i  (test_en_i),
    .quick_i    (quick_i),
    .keep_i     (keep_i),
    .last_row_i (last_row),
    .ctl_o      (ctl),
    .start_o    (start),
    .row_end_o  (row_end),
    .cap_o      (cap),
    .busy_o     (busy),
    .done_o     (done_o)
  );

  obd_row_ctr #(.ROWS(ROWS), .ROW_W(ROW_W)) i_row (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .inc_i  (row_end),
    .row_o  (row_o),
    .last_o (last_row)
  );

  obd_hold_reg #(.WIDTH(WIDTH)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .d_i    (rdata_i),
    .q_o    (wdata_o)
  );

  obd_fail_rec #(.WIDTH(WIDTH), .ROW_W(ROW_W)) i_rec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (start),
    .up_stb_i     (ctl.stb_up),
    .dn_stb_i     (ctl.stb_dn),
    .up_i         (fail_up_i),
    .dn_i         (fail_dn_i),
    .row_i        (row_o),
    .fault_o      (fault_o),
    .fault_row_o  (fault_row_o),
    .fault_cols_o (fault_cols_o)
  );

  assign busy_o      = busy;
  assign stall_o     = req_i && busy;
  assign pch_dis_o   = ctl.pch_dis;
  assign we_o        = ctl.we;
  assign bl_gnd_o    = ctl.bl_gnd;
  assign wl_en_o     = ctl.wl_en;
  assign col_sel_o   = ctl.col_sel;
  assign rd_o        = ctl.rd;
  assign strobe_up_o = ctl.stb_up;
  assign strobe_dn_o = ctl.stb_dn;

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R10
  AST_GND_ONLY_WRITING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bl_gnd_o |-> (we_o && pch_dis_o && wl_en_o)); // R3

endmodule

// File: tb/test_obd_test_seq.sv
module test_obd_test_seq;

  localparam int ROWS  = 4;
  localparam int WIDTH = 8;
  localparam int ROW_W = 2;

  // {fail_up, fail_dn, stored word} per row
  localparam logic [23:0] VEC [ROWS] = '{
    {8'h00, 8'h00, 8'hA5},
    {8'h04, 8'h00, 8'h3C},
    {8'h00, 8'h00, 8'hFF},
    {8'h01, 8'h80, 8'h00}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic test_en_i = 1'b0, quick_i = 1'b0, keep_i = 1'b0, req_i = 1'b0;
  logic [WIDTH-1:0] rdata_i = '0, fail_up_i = '0, fail_dn_i = '0;
  logic busy_o, stall_o, pch_dis_o, we_o, bl_gnd_o, wl_en_o, col_sel_o, rd_o;
  logic strobe_up_o, strobe_dn_o, fault_o, done_o;
  logic [ROW_W-1:0] row_o, fault_row_o;
  logic [WIDTH-1:0] wdata_o, fault_cols_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  obd_test_seq #(.ROWS(ROWS), .WIDTH(WIDTH)) i_obd_test_seq (
    .clk_i, .rst_ni, .test_en_i, .quick_i, .keep_i, .req_i, .rdata_i,
    .fail_up_i, .fail_dn_i, .busy_o, .stall_o, .pch_dis_o, .we_o, .bl_gnd_o,
    .wl_en_o, .col_sel_o, .rd_o, .strobe_up_o, .strobe_dn_o, .row_o, .wdata_o,
    .fault_o, .fault_row_o, .fault_cols_o, .done_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic             exp_fault;
    logic [ROW_W-1:0] exp_frow;
    logic [WIDTH-1:0] exp_fcols;
    exp_fault = 1'b0; exp_frow = '0; exp_fcols = '0;

    #22 rst_ni = 1'b1;
    tick();
    // R1 reset state
    chk("R1 idle controls", {busy_o, stall_o, done_o, fault_o, pch_dis_o, we_o, bl_gnd_o,
        wl_en_o, col_sel_o, rd_o, strobe_up_o, strobe_dn_o}, 32'h0);
    chk("R1 row zero", row_o, 0);
    req_i = 1'b1;
    #1 chk("R11 no stall when idle", stall_o, 0);

    // Full scan with save/restore, walked from the vector table
    test_en_i = 1'b1; keep_i = 1'b1; quick_i = 1'b0;
    tick();
    for (int r = 0; r < ROWS; r++) begin
      logic [WIDTH-1:0] up, dn, dat;
      {up, dn, dat} = VEC[r];
      chk("R2 save cycle rd/wl", {rd_o, wl_en_o, we_o}, 3'b110);
      chk("R10 row index", row_o, r);
      chk("R11 busy/stall", {busy_o, stall_o}, 2'b11);
      rdata_i = dat; test_en_i = 1'b0;
      tick();
      rdata_i = ~dat;
      chk("R3 ground cycle", {pch_dis_o, we_o, bl_gnd_o, wl_en_o}, 4'b1111);
      tick();
      chk("R4 float cycle", {pch_dis_o, we_o, bl_gnd_o, wl_en_o, strobe_up_o}, 5'b10011);
      fail_up_i = up;
      tick();
      fail_up_i = '0;
      chk("R5 precharge cycle", {pch_dis_o, wl_en_o, strobe_dn_o}, 3'b000);
      tick();
      chk("R5 sense cycle", {pch_dis_o, wl_en_o, strobe_dn_o}, 3'b111);
      fail_dn_i = dn;
      tick();
      fail_dn_i = '0;
      chk("R6 restore cycle", {we_o, bl_gnd_o, wl_en_o}, 3'b101);
      chk("R6 restore data", wdata_o, dat);
      if ((up | dn) != 0) begin
        exp_fault = 1'b1; exp_frow = ROW_W'(r); exp_fcols = up | dn;
      end
      chk("R9 fault flag", fault_o, exp_fault);
      chk("R9 fault row", fault_row_o, exp_frow);
      chk("R9 fault cols", fault_cols_o, exp_fcols);
      tick();
    end
    chk("R10 done after last row", {done_o, busy_o}, 2'b10);
    chk("R10 row wraps", row_o, 0);
    chk("R11 stall released", stall_o, 0);

    // No-save scan: four cycles per row
    test_en_i = 1'b1; keep_i = 1'b0;
    tick();
    test_en_i = 1'b0;
    chk("R10 done cleared on start", done_o, 0);
    chk("R9 record cleared on start", {fault_o, fault_cols_o}, 0);
    for (int r = 0; r < ROWS; r++) begin
      chk("R7 row starts grounding", {bl_gnd_o, rd_o}, 2'b10);
      chk("R7 row index", row_o, r);
      tick(); tick(); tick();
      chk("R7 sense is fourth cycle", strobe_dn_o, 1);
      tick();
    end
    chk("R7 scan ends", {done_o, busy_o}, 2'b10);

    // Quick scan: two cycles per row, mode inputs flipped mid-scan
    test_en_i = 1'b1; quick_i = 1'b1; keep_i = 1'b1;
    tick();
    test_en_i = 1'b0; quick_i = 1'b0; keep_i = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      chk("R8 precharge first", {pch_dis_o, we_o, bl_gnd_o, rd_o}, 4'b0000);
      chk("R12 mode held row index", row_o, r);
      tick();
      chk("R8 sense second", {strobe_dn_o, we_o, bl_gnd_o}, 3'b100);
      if (r == 2) fail_dn_i = 8'h10;
      tick();
      fail_dn_i = '0;
    end
    chk("R8 quick scan done", {done_o, busy_o}, 2'b10);
    chk("R9 quick fault row", {fault_o, fault_row_o}, {1'b1, 2'd2});
    chk("R9 quick fault cols", fault_cols_o, 8'h10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule